// File: doc/BRIEF.md
# Streaming Flash Program Sequencer

This block is a write state machine for a flash-style memory array that has a fast streaming program mode. The host enters the mode with a two-write command sequence, and the second write carries the start address. After that, every host write carries only a data word. The host polls a status byte between words. For each accepted word the sequencer applies a timed program pulse to an internal behavioural array and then compares the stored word with the intended value. If they match, it moves to the next address by itself. If they differ, it retries a limited number of times.

Programming can only clear bits, so a stored word becomes the old contents ANDed with the new data. A word that asks for a 0 to turn back into a 1 can therefore never verify. Streaming ends in one of four ways:
- the last word of a power-of-two block has been written;
- the host writes the all-ones exit word to an address in a different block;
- a verify failure that retries cannot fix;
- the programming-voltage-valid input is low when a write arrives.

A low voltage-valid input refuses the operation and raises an error flag. Error flags stay set until a clear command is written in idle.

Top module: `flash_stream_prog`

## Requirements
- R1: In idle, a write of code 0x30 followed by a write of code 0xD0 (codes on din[7:0]) enters streaming and latches the start address from the address bus of the 0xD0 write. Status then reads 0x81: bit 7 is ready and bit 0 is streaming.
- R2: In the setup step, any code other than 0xD0 returns the block to idle and sets status bit 5 (sequence error).
- R3: A data write in streaming stores old AND data at the current address. Status bit 7 is 0 for exactly PULSE_CYC+1 cycles (pulse, then verify) and returns to 1 only after the word has verified.
- R4: After each verified word the target address increments by one. The address bus is ignored for data words, so consecutive words land at consecutive locations.
- R5: Verifying the word at the last location of a block (address low BLK_LOG2 bits all ones) ends streaming, and status returns to 0x80.
- R6: Writing the all-ones word to an address whose block index differs from the current one ends streaming without programming anything.
- R7: If vpp_ok is low when code 0x30 is written in idle, or when a data word is written in streaming, the operation is refused. Status bit 3 is set, streaming ends and the array is unchanged.
- R8: On a verify mismatch the pulse is repeated up to MAX_RETRY times. If the word still mismatches, status bit 4 is set and streaming is aborted, after (MAX_RETRY+1)*(PULSE_CYC+1) busy cycles.
- R9: Error bits 3, 4 and 5 stay set until code 0x50 is written in idle, which clears them.
- R10: A read strobe copies the array word at addr into rdata one cycle later. After reset every array word reads all ones.
- R11: After reset, status is 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host array read strobe |
| addr | input | AW | Address: used for the start address, the exit check and reads |
| din | input | DW | Command code (low byte) or data word |
| vpp_ok | input | 1 | Programming voltage above lockout |
| status | output | 8 | Status: bit 7 ready, bit 5 sequence error, bit 4 program error, bit 3 voltage error, bit 0 streaming |
| rdata | output | DW | Array read data |

## Verification
Several properties are checked on every cycle:
- streaming is only ever entered straight after a confirm write;
- the address steps by exactly one whenever a word completes;
- a write under low voltage always flags and leaves streaming;
- the program error flag never drops without a clear write;
- no busy period lasts longer than the full retry budget.

Only the directed scenarios can show the remaining behaviour. This covers the values actually stored in the array, the exact busy length for a good word and for a failing one, the end of streaming at the block edge and on the exit word, and the array staying untouched after a refused or ignored write.

// File: rtl/flash_stream_prog.sv
module flash_stream_prog #(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int BLK_LOG2  = 4,
  parameter int PULSE_CYC = 3,
  parameter int MAX_RETRY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          vpp_ok,
  output logic [7:0]    status,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(PULSE_CYC + 1);
  localparam int RW    = $clog2(MAX_RETRY + 2);
  localparam logic [7:0] C_SETUP = 8'h30;
  localparam logic [7:0] C_CONF  = 8'hD0;
  localparam logic [7:0] C_CLEAR = 8'h50;
  localparam logic [DW-1:0] EXIT_WORD = '1;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_RDY, S_PULSE, S_VFY} st_t;

  st_t            st;
  logic [AW-1:0]  ptr;
  logic [DW-1:0]  wdata;
  logic [CW-1:0]  cnt;
  logic [RW-1:0]  retry;
  logic           err_seq, err_prog, err_vpp;
  logic [DW-1:0]  mem [DEPTH];

  wire ready     = (st == S_IDLE) || (st == S_SETUP) || (st == S_RDY);
  wire streaming = (st == S_RDY) || (st == S_PULSE) || (st == S_VFY);
  wire other_blk = addr[AW-1:BLK_LOG2] != ptr[AW-1:BLK_LOG2];
  wire last_loc  = &ptr[BLK_LOG2-1:0];
  wire match     = mem[ptr] == wdata;

  assign status = {ready, 1'b0, err_seq, err_prog, err_vpp, 2'b00, streaming};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ptr      <= '0;
      wdata    <= '0;
      cnt      <= '0;
      retry    <= '0;
      err_seq  <= 1'b0;
      err_prog <= 1'b0;
      err_vpp  <= 1'b0;
      rdata    <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      if (rd_en) rdata <= mem[addr];
      case (st)
        S_IDLE:
          if (wr_en) begin
            if (din[7:0] == C_SETUP) begin
              if (vpp_ok) st <= S_SETUP;
              else        err_vpp <= 1'b1;
            end else if (din[7:0] == C_CLEAR) begin
              err_seq  <= 1'b0;
              err_prog <= 1'b0;
              err_vpp  <= 1'b0;
            end
          end
        S_SETUP:
          if (wr_en) begin
            if (din[7:0] == C_CONF) begin
              ptr <= addr;
              st  <= S_RDY;
            end else begin
              err_seq <= 1'b1;
              st      <= S_IDLE;
            end
          end
        S_RDY:
          if (wr_en) begin
            if (!vpp_ok) begin
              err_vpp <= 1'b1;
              st      <= S_IDLE;
            end else if (din == EXIT_WORD && other_blk) begin
              st <= S_IDLE;
            end else begin
              wdata <= din;
              cnt   <= '0;
              retry <= '0;
              st    <= S_PULSE;
            end
          end
        S_PULSE:
          if (cnt == CW'(PULSE_CYC - 1)) begin
            mem[ptr] <= mem[ptr] & wdata;
            st       <= S_VFY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_VFY:
          if (match) begin
            ptr <= ptr + 1'b1;
            st  <= last_loc ? S_IDLE : S_RDY;
          end else if (retry < RW'(MAX_RETRY)) begin
            retry <= retry + 1'b1;
            cnt   <= '0;
            st    <= S_PULSE;
          end else begin
            err_prog <= 1'b1;
            st       <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_stream_prog_chk.sv
module flash_stream_prog_chk #(
  parameter int AW        = 8,
  parameter int PULSE_CYC = 3,
  parameter int MAX_RETRY = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [7:0]    cmd,
  input logic          vpp_ok,
  input logic          ready,
  input logic          streaming,
  input logic          prog_err,
  input logic          vpp_err,
  input logic [AW-1:0] ptr
);
  localparam int LIMIT = (MAX_RETRY + 1) * (PULSE_CYC + 1);
  logic [15:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || ready) busy_cnt <= '0;
    else                 busy_cnt <= busy_cnt + 1'b1;
  end

  a_r1_enter_on_confirm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(streaming) |-> $past(wr_en && cmd == 8'hD0));

  a_r4_addr_steps_one: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) && streaming) |-> ptr == AW'($past(ptr) + 1'b1));

  a_r7_low_vpp_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !vpp_ok && ready && streaming) |=> (vpp_err && !streaming));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    prog_err |=> (prog_err || $past(wr_en && cmd == 8'h50)));

  a_r8_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= 16'(LIMIT));
endmodule

bind flash_stream_prog flash_stream_prog_chk #(
  .AW(AW), .PULSE_CYC(PULSE_CYC), .MAX_RETRY(MAX_RETRY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd(din[7:0]), .vpp_ok(vpp_ok),
  .ready(status[7]), .streaming(status[0]), .prog_err(status[4]),
  .vpp_err(status[3]), .ptr(ptr)
);

// File: tb/flash_stream_prog_test.sv
module flash_stream_prog_test;
  localparam int AW = 8, DW = 16, P = 3, RT = 2;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, vpp_ok = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [7:0] status;
  logic [DW-1:0] rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flash_stream_prog #(.AW(AW), .DW(DW), .BLK_LOG2(4), .PULSE_CYC(P), .MAX_RETRY(RT)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .din(din), .vpp_ok(vpp_ok), .status(status), .rdata(rdata));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); addr = a; din = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!status[7] && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic word(logic [AW-1:0] a, logic [DW-1:0] d, int exp_busy, string req);
    int n;
    wr(a, d);
    wait_ready(n);
    chk(req, n, exp_busy);
  endtask

  task automatic enter(logic [AW-1:0] a);
    wr('0, 16'h0030);
    wr(a, 16'h00D0);
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    chk("R11 reset status", status, 8'h80);
    rd(8'h05, d);
    chk("R10 erased word", d, 16'hFFFF);
  endtask

  task automatic t_stream;
    logic [DW-1:0] d;
    enter(8'h20);
    chk("R1 streaming status", status, 8'h81);
    word(8'h20, 16'hA5A5, P + 1, "R3 busy length");
    word(8'h77, 16'h1234, P + 1, "R3 busy length");
    word(8'h03, 16'h0F0F, P + 1, "R3 busy length");
    chk("R3 ready again", status, 8'h81);
    rd(8'h20, d); chk("R4 word 0", d, 16'hA5A5);
    rd(8'h21, d); chk("R4 word 1 ignores addr", d, 16'h1234);
    rd(8'h22, d); chk("R4 word 2", d, 16'h0F0F);
  endtask

  task automatic t_exit;
    logic [DW-1:0] d;
    wr(8'h90, 16'hFFFF);
    chk("R6 exit status", status, 8'h80);
    rd(8'h23, d); chk("R6 no program", d, 16'hFFFF);
    rd(8'h90, d); chk("R6 other block untouched", d, 16'hFFFF);
  endtask

  task automatic t_boundary;
    logic [DW-1:0] d;
    enter(8'h3E);
    word(8'h00, 16'h5555, P + 1, "R5 word busy");
    chk("R5 still streaming", status, 8'h81);
    word(8'h00, 16'h00F0, P + 1, "R5 last word busy");
    chk("R5 stream ended", status, 8'h80);
    rd(8'h3F, d); chk("R5 last word stored", d, 16'h00F0);
    rd(8'h40, d); chk("R5 next block untouched", d, 16'hFFFF);
  endtask

  task automatic t_mismatch;
    logic [DW-1:0] d;
    enter(8'h20);
    word(8'h20, 16'hFFFE, (RT + 1) * (P + 1), "R8 retry busy length");
    chk("R8 program error", status, 8'h90);
    rd(8'h20, d); chk("R8 and-programmed", d, 16'hA5A4);
  endtask

  task automatic t_sticky;
    wr('0, 16'h0000);
    chk("R9 error kept", status, 8'h90);
    wr('0, 16'h0050);
    chk("R9 cleared", status, 8'h80);
  endtask

  task automatic t_badseq;
    wr('0, 16'h0030);
    wr('0, 16'h0077);
    chk("R2 sequence error", status, 8'hA0);
    wr('0, 16'h0050);
    chk("R9 clear seq error", status, 8'h80);
  endtask

  task automatic t_vpp;
    logic [DW-1:0] d;
    vpp_ok = 1'b0;
    wr('0, 16'h0030);
    chk("R7 setup refused", status, 8'h88);
    wr('0, 16'h0050);
    vpp_ok = 1'b1;
    enter(8'h50);
    vpp_ok = 1'b0;
    wr(8'h50, 16'h0000);
    chk("R7 data refused", status, 8'h88);
    vpp_ok = 1'b1;
    rd(8'h50, d); chk("R7 array unchanged", d, 16'hFFFF);
    wr('0, 16'h0050);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_stream;
    t_exit;
    t_boundary;
    t_mismatch;
    t_sticky;
    t_badseq;
    t_vpp;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule